// File: doc/BRIEF.md
# Rotation Coprocessor Register Front End

This block sits between a simple 32-bit memory-mapped bus and a fixed-point rotation engine. Software programs a control word, writes one or two arguments into an argument register, and reads one or two results back from a result register. The front end counts argument writes and expands packed 16-bit pairs. It holds a complete argument set until the engine is free and the previous results have been read. It then launches the engine with a one-cycle start pulse and captures the results when the engine answers with a one-cycle done pulse.

A ready flag marks unread results. It stays set until the configured number of result reads has been made. The flag drives an interrupt line and a DMA read request, each gated by its own enable. A DMA write request signals that the block can accept another argument set. The arithmetic engine is a stand-in with a deterministic transfer function and a latency that depends on the precision field.

Top module: `rot_regif`

## Requirements
- R1: Three registers are decoded: control at offset 0x0, argument at 0x4 and result at 0x8. After reset, control and result read as zero. The writable control fields are: function bits 3:0, precision bits 7:4, scale bits 10:8, interrupt enable bit 16, DMA-read enable bit 17, DMA-write enable bit 18, two-results bit 19, two-arguments bit 20, 16-bit results bit 21 and 16-bit arguments bit 22. All other bits read zero.
- R2: Bit 31 of the control register is the ready flag. It is read-only, and writing it has no effect.
- R3: With 32-bit arguments and bit 20 clear, one argument write triggers a calculation. The secondary argument is then zero.
- R4: With 32-bit arguments and bit 20 set, two writes are needed: the primary argument first, then the secondary. A single write launches nothing.
- R5: With 16-bit arguments, one write triggers a calculation. Bits 15:0 become the upper half of the primary argument and bits 31:16 become the upper half of the secondary argument; both lower halves are zero.
- R6: The engine stand-in returns primary = a1 + a2 + function and secondary = (a1 - a2) logically shifted right by scale, both modulo 2^32. It completes 2 + precision cycles after its start.
- R7: Ready sets on completion. With 32-bit results and bit 19 set, the first read returns the primary result and leaves ready set. The second read returns the secondary result and clears ready.
- R8: With 32-bit results and bit 19 clear, one read returns the primary result and clears ready. With 16-bit results, one read returns the upper half of the secondary result in bits 31:16 and the upper half of the primary result in bits 15:0, and it clears ready.
- R9: No calculation starts while ready is set or the engine is busy. A complete argument set arriving then is held, and it launches after the outstanding results are read.
- R10: Any argument write while a set is pending cancels that set. Only the newest complete set is computed. A partial write leaves nothing pending.
- R11: The interrupt equals interrupt enable AND ready. The DMA read request equals DMA-read enable AND ready. The DMA write request equals DMA-write enable AND no set pending.
- R12: A write to the control register resets the argument-write count and the result-read count.
- R13: Reads of the argument register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte offset of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| dma_rd_req_o | output | 1 | DMA read request |
| dma_wr_req_o | output | 1 | DMA write request |

## Verification
The bench holds a second argument set while results are still unread. A design that launched early would return the new result in place of the old one, or lose it. It cancels a pending set with a full set and with a half-written one. A design that kept the stale set would produce an extra result after the read. It writes the control register between the two halves of an argument pair and counts ready across the two reads of a result pair. A miscounting design would pair the wrong words or clear ready one read early. It also checks the lane placement of 16-bit arguments and results.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
package rot_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = DW / 2;

  typedef struct packed {
    logic [3:0] func;
    logic [3:0] prec;
    logic [2:0] scale;
    logic       ien;
    logic       drd_en;
    logic       dwr_en;
    logic       nres2;
    logic       nargs2;
    logic       res16;
    logic       arg16;
  } cfg_t;

  function automatic logic [DW-1:0] pack_cfg(cfg_t c, logic rdy);
    logic [DW-1:0] w;
    w        = '0;
    w[3:0]   = c.func;
    w[7:4]   = c.prec;
    w[10:8]  = c.scale;
    w[16]    = c.ien;
    w[17]    = c.drd_en;
    w[18]    = c.dwr_en;
    w[19]    = c.nres2;
    w[20]    = c.nargs2;
    w[21]    = c.res16;
    w[22]    = c.arg16;
    w[31]    = rdy;
    return w;
  endfunction
endpackage

// File: rtl/rot_arg_collect.sv
`timescale 1ns/1ps
module rot_arg_collect
  import rot_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          arg16_i,
  input  logic          nargs2_i,
  input  logic          clr_i,
  input  logic          launch_i,
  output logic          pend_o,
  output logic [DW-1:0] arg1_o,
  output logic [DW-1:0] arg2_o
);
  logic          wcnt_q, pend_q;
  logic [DW-1:0] a1_q, a2_q;
  logic          complete;

  assign complete = wr_i && (arg16_i || !nargs2_i || wcnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= 1'b0;
      pend_q <= 1'b0;
      a1_q   <= '0;
      a2_q   <= '0;
    end else begin
      if (clr_i) begin
        wcnt_q <= 1'b0;
      end else if (wr_i) begin
        if (arg16_i) begin
          a1_q   <= {wdata_i[HW-1:0], {HW{1'b0}}};
          a2_q   <= {wdata_i[DW-1:HW], {HW{1'b0}}};
          wcnt_q <= 1'b0;
        end else if (!nargs2_i) begin
          a1_q   <= wdata_i;
          a2_q   <= '0;
          wcnt_q <= 1'b0;
        end else if (!wcnt_q) begin
          a1_q   <= wdata_i;
          wcnt_q <= 1'b1;
        end else begin
          a2_q   <= wdata_i;
          wcnt_q <= 1'b0;
        end
      end
      // any write replaces a pending set; only a completing one re-arms it
      if (wr_i)          pend_q <= complete;
      else if (launch_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign arg1_o = a1_q;
  assign arg2_o = a2_q;

  // R9
  launch_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> pend_q);
  // R12
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wcnt_q);
endmodule

// File: rtl/rot_res_seq.sv
`timescale 1ns/1ps
module rot_res_seq
  import rot_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] r1_i,
  input  logic [DW-1:0] r2_i,
  input  logic          rd_i,
  input  logic          clr_i,
  input  logic          res16_i,
  input  logic          nres2_i,
  output logic          ready_o,
  output logic [DW-1:0] word_o
);
  logic          ready_q, rcnt_q;
  logic [DW-1:0] r1_q, r2_q;
  logic          last_rd;

  assign last_rd = res16_i || !nres2_i || rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rcnt_q  <= 1'b0;
      r1_q    <= '0;
      r2_q    <= '0;
    end else if (done_i) begin
      r1_q    <= r1_i;
      r2_q    <= r2_i;
      ready_q <= 1'b1;
      rcnt_q  <= 1'b0;
    end else if (clr_i) begin
      rcnt_q  <= 1'b0;
    end else if (rd_i && ready_q) begin
      if (last_rd) begin
        ready_q <= 1'b0;
        rcnt_q  <= 1'b0;
      end else begin
        rcnt_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    if (res16_i)     word_o = {r2_q[DW-1:HW], r1_q[DW-1:HW]};
    else if (rcnt_q) word_o = r2_q;
    else             word_o = r1_q;
  end

  assign ready_o = ready_q;

  // R7
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (ready_q && !rcnt_q));
  // R8
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ready_q && !done_i && !clr_i && (res16_i || !nres2_i)) |=> !ready_q);
endmodule

// File: rtl/rot_engine_stub.sv
`timescale 1ns/1ps
module rot_engine_stub
  import rot_pkg::*;
#(
  parameter int unsigned LAT_BASE = 2  // must be at least 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] a1_i,
  input  logic [DW-1:0] a2_i,
  input  logic [3:0]    func_i,
  input  logic [3:0]    prec_i,
  input  logic [2:0]    scale_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] r1_o,
  output logic [DW-1:0] r2_o
);
  localparam int unsigned CW = $clog2(LAT_BASE + 16) + 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] r1_q, r2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      r1_q   <= '0;
      r2_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LAT_BASE) + CW'(prec_i);
      r1_q   <= a1_i + a2_i + DW'(func_i);
      r2_q   <= (a1_i - a2_i) >> scale_i;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1));
  assign r1_o   = r1_q;
  assign r2_o   = r2_q;
endmodule

// File: rtl/rot_regif.sv
`timescale 1ns/1ps
module rot_regif
  import rot_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned LAT_BASE = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          dma_rd_req_o,
  output logic          dma_wr_req_o
);
  localparam logic [AW-1:0] OFS_CSR = AW'(0);
  localparam logic [AW-1:0] OFS_ARG = AW'(4);
  localparam logic [AW-1:0] OFS_RES = AW'(8);

  cfg_t          cfg_q;
  logic          wr_csr, wr_arg, rd_res;
  logic          pend, start, busy, done, ready;
  logic [DW-1:0] arg1, arg2, r1, r2, res_word;

  assign wr_csr = wr_i && (addr_i == OFS_CSR);
  assign wr_arg = wr_i && (addr_i == OFS_ARG);
  assign rd_res = rd_i && (addr_i == OFS_RES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_csr) begin
      cfg_q.func   <= wdata_i[3:0];
      cfg_q.prec   <= wdata_i[7:4];
      cfg_q.scale  <= wdata_i[10:8];
      cfg_q.ien    <= wdata_i[16];
      cfg_q.drd_en <= wdata_i[17];
      cfg_q.dwr_en <= wdata_i[18];
      cfg_q.nres2  <= wdata_i[19];
      cfg_q.nargs2 <= wdata_i[20];
      cfg_q.res16  <= wdata_i[21];
      cfg_q.arg16  <= wdata_i[22];
    end
  end

  rot_arg_collect u_args (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_arg),
    .wdata_i  (wdata_i),
    .arg16_i  (cfg_q.arg16),
    .nargs2_i (cfg_q.nargs2),
    .clr_i    (wr_csr),
    .launch_i (start),
    .pend_o   (pend),
    .arg1_o   (arg1),
    .arg2_o   (arg2)
  );

  // launch only into an idle engine with no unread results
  assign start = pend && !busy && !ready;

  rot_engine_stub #(.LAT_BASE(LAT_BASE)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .a1_i    (arg1),
    .a2_i    (arg2),
    .func_i  (cfg_q.func),
    .prec_i  (cfg_q.prec),
    .scale_i (cfg_q.scale),
    .busy_o  (busy),
    .done_o  (done),
    .r1_o    (r1),
    .r2_o    (r2)
  );

  rot_res_seq u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .r1_i    (r1),
    .r2_i    (r2),
    .rd_i    (rd_res),
    .clr_i   (wr_csr),
    .res16_i (cfg_q.res16),
    .nres2_i (cfg_q.nres2),
    .ready_o (ready),
    .word_o  (res_word)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CSR)      rdata_o = pack_cfg(cfg_q, ready);
    else if (addr_i == OFS_RES) rdata_o = res_word;
  end

  assign irq_o        = cfg_q.ien && ready;
  assign dma_rd_req_o = cfg_q.drd_en && ready;
  assign dma_wr_req_o = cfg_q.dwr_en && !pend;

  // R9
  done_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !ready);
  // R9
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
endmodule

// File: tb/rot_regif_tb.sv
`timescale 1ns/1ps
module rot_regif_tb;
  localparam logic [7:0] A_CSR = 8'h00, A_ARG = 8'h04, A_RES = 8'h08;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, dma_rd_req_o, dma_wr_req_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] cfg;
  logic [31:0] d;

  always #10 clk_i = ~clk_i;

  rot_regif u_dut (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .irq_o, .dma_rd_req_o, .dma_wr_req_o
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk_i);
    addr_i = a; wdata_i = v; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  function automatic logic [31:0] mk(int func, int prec, int scale, bit ien, bit drd,
                                     bit dwr, bit nres2, bit nargs2, bit res16, bit arg16);
    logic [31:0] w = '0;
    w[3:0] = 4'(func); w[7:4] = 4'(prec); w[10:8] = 3'(scale);
    w[16] = ien; w[17] = drd; w[18] = dwr; w[19] = nres2;
    w[20] = nargs2; w[21] = res16; w[22] = arg16;
    return w;
  endfunction

  // driver side of the scoreboard: expected words per R6/R7/R8
  task automatic push_set(logic [31:0] a1, logic [31:0] a2, logic [31:0] c);
    logic [31:0] p, s;
    p = a1 + a2 + {28'd0, c[3:0]};
    s = (a1 - a2) >> c[10:8];
    if (c[21]) exp_q.push_back({s[31:16], p[31:16]});
    else begin
      exp_q.push_back(p);
      if (c[19]) exp_q.push_back(s);
    end
  endtask

  // monitor side: one result read compared against the queue head
  task automatic pop_read(string tag);
    logic [31:0] v, e;
    bus_rd(A_RES, v);
    if (exp_q.size() == 0) begin
      chk({tag, " queue empty"}, v, 32'hxxxx_xxxx);
    end else begin
      e = exp_q.pop_front();
      chk(tag, v, e);
    end
  endtask

  task automatic wait_ready(string tag);
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 200; i++) begin
      bus_rd(A_CSR, v);
      if (v[31]) begin seen = 1; break; end
    end
    if (!seen) chk({tag, " ready timeout"}, 32'd0, 32'd1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R9 got hang exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state
    bus_rd(A_CSR, d); chk("R1 csr reset", d, 32'h0);
    bus_rd(A_RES, d); chk("R1 res reset", d, 32'h0);
    chk("R11 outputs reset", {29'd0, irq_o, dma_rd_req_o, dma_wr_req_o}, 32'h0);
    // R1 R2 field mask, bit 31 not writable
    bus_wr(A_CSR, 32'hFFFF_FFFF);
    bus_rd(A_CSR, d); chk("R1 R2 csr mask", d, 32'h007F_07FF);
    chk("R11 dma_wr idle", {31'd0, dma_wr_req_o}, 32'd1);
    chk("R11 irq without ready", {31'd0, irq_o}, 32'd0);
    // R13
    bus_wr(A_ARG, 32'hDEAD_BEEF);
    bus_rd(A_ARG, d); chk("R13 arg reads zero", d, 32'h0);
    bus_wr(A_CSR, 32'h0);
    idle(40);
    bus_rd(A_RES, d); // drain whatever the packed write produced
    exp_q.delete();

    // R3 single 32-bit argument, single result
    cfg = mk(3, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'h1000_0000); push_set(32'h1000_0000, 32'h0, cfg);
    wait_ready("R3");
    chk("R11 irq with ready", {31'd0, irq_o}, 32'd1);
    pop_read("R3 R6 primary");
    bus_rd(A_CSR, d); chk("R8 ready cleared", {31'd0, d[31]}, 32'd0);
    chk("R11 irq cleared", {31'd0, irq_o}, 32'd0);

    // R7 two results, second arg zero (R3)
    cfg = mk(0, 2, 2, 0, 0, 0, 1, 0, 0, 0);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'h0000_0100); push_set(32'h100, 32'h0, cfg);
    wait_ready("R7");
    pop_read("R7 primary");
    bus_rd(A_CSR, d); chk("R7 ready after first read", {31'd0, d[31]}, 32'd1);
    pop_read("R7 secondary R3");
    bus_rd(A_CSR, d); chk("R7 ready after second read", {31'd0, d[31]}, 32'd0);

    // R4 two-write trigger
    cfg = mk(0, 0, 1, 0, 0, 0, 1, 1, 0, 0);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'h20);
    idle(40);
    bus_rd(A_CSR, d); chk("R4 no launch on one write", {31'd0, d[31]}, 32'd0);
    bus_wr(A_ARG, 32'h08); push_set(32'h20, 32'h08, cfg);
    wait_ready("R4");
    pop_read("R4 primary");
    pop_read("R4 secondary");

    // R12 control write restarts the argument count
    bus_wr(A_ARG, 32'h5555);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'h30);
    bus_wr(A_ARG, 32'h10); push_set(32'h30, 32'h10, cfg);
    wait_ready("R12");
    pop_read("R12 primary");
    pop_read("R12 secondary");

    // R5 R8 packed 16-bit arguments and results
    cfg = mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'h2000_1000); push_set(32'h1000_0000, 32'h2000_0000, cfg);
    wait_ready("R5");
    pop_read("R5 R8 packed");
    bus_rd(A_CSR, d); chk("R8 packed read clears", {31'd0, d[31]}, 32'd0);

    // R9 held set while result unread
    cfg = mk(1, 3, 0, 0, 1, 1, 0, 0, 0, 0);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'h100); push_set(32'h100, 32'h0, cfg);
    wait_ready("R9 A");
    chk("R11 dma_rd with ready", {31'd0, dma_rd_req_o}, 32'd1);
    bus_wr(A_ARG, 32'h200); push_set(32'h200, 32'h0, cfg);
    idle(30);
    chk("R11 dma_wr while pending", {31'd0, dma_wr_req_o}, 32'd0);
    bus_rd(A_CSR, d); chk("R9 ready held", {31'd0, d[31]}, 32'd1);
    pop_read("R9 old result kept");
    wait_ready("R9 B");
    pop_read("R9 held set launched");
    chk("R11 dma_wr after launch", {31'd0, dma_wr_req_o}, 32'd1);

    // R10 full-set cancel
    bus_wr(A_ARG, 32'h300); push_set(32'h300, 32'h0, cfg);
    wait_ready("R10 A");
    bus_wr(A_ARG, 32'h400);
    bus_wr(A_ARG, 32'h500); push_set(32'h500, 32'h0, cfg);
    pop_read("R10 first");
    wait_ready("R10 C");
    pop_read("R10 newest set only");
    idle(40);
    bus_rd(A_CSR, d); chk("R10 cancelled set not run", {31'd0, d[31]}, 32'd0);

    // R10 partial-write cancel
    cfg = mk(2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    bus_wr(A_CSR, cfg);
    bus_wr(A_ARG, 32'd1);
    bus_wr(A_ARG, 32'd2); push_set(32'd1, 32'd2, cfg);
    wait_ready("R10 P");
    bus_wr(A_ARG, 32'd5);
    bus_wr(A_ARG, 32'd6);
    bus_wr(A_ARG, 32'd7);
    pop_read("R10 partial first");
    idle(40);
    bus_rd(A_CSR, d); chk("R10 partial leaves nothing", {31'd0, d[31]}, 32'd0);
    bus_wr(A_ARG, 32'd1); push_set(32'd7, 32'd1, cfg);
    wait_ready("R10 Q");
    pop_read("R10 completed after cancel");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule